// File: doc/BRIEF.md
# Divider Configuration Loader

This block stores the settings of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit selector for a test pin. The active settings can be written from parallel pins or from a three-wire serial port made of a data line, a shift clock and a load strobe. The active feedback value and output code go to the divider logic. The output code is also given as a decoded divide ratio.

All pins are sampled on the system clock `clk`. Edges on the serial clock, the serial load strobe and the parallel load strobe are found by comparing each pin with its value on the previous `clk` cycle. Serial bits pass through three stages before they take effect: a shift register, a transfer register and the active register. While the serial load strobe is held high, the active register follows newly shifted bits.

The test pin outputs one of four things, picked by the stored selector: a constant low, the serial data line, the feedback-divider clock or the output clock. An out-of-range flag is raised whenever the active feedback value lies outside the range in which the loop can lock. The value is still applied when the flag is raised.

Top module: `cfg_loader`

## Requirements
- R1: While `pLoadN` is 0, `mActive` and `nCode` take the values of `mPar` and `nPar` one `clk` cycle later, and go on following them.
- R2: Once `pLoadN` has gone from 0 to 1, the values present on that edge are held, and later changes on `mPar`/`nPar` have no effect.
- R3: With `pLoadN` at 1 and `sLoad` at 0, each rising `sClk` shifts `sData` into a 14-bit frame. The bit order, first to last, is selector bit 1, selector bit 0, a null slot, N bit 1, N bit 0, then M bit 8 down to M bit 0. The active values do not change until `sLoad` rises, and are updated within three `clk` cycles after that.
- R4: After `sLoad` falls, further serial frames shifted in leave `mActive` and `nCode` unchanged until the next rise of `sLoad`.
- R5: While `sLoad` stays at 1, bits shifted in on `sClk` reach the active register without a new `sLoad` edge.
- R6: With `pLoadN` at 1, `testOut` shows the serial-loaded selector as follows: 00 gives 0, 01 gives `sData`, 10 gives `mDivClk`, and 11 gives `outClk`.
- R7: While `pLoadN` is 0, `testOut` is 0 whatever the stored selector is.
- R8: `mOutOfRange` is 1 exactly when `mActive` is below 10 or above 28.
- R9: `divRatio` is a one-hot value equal to 1 shifted left by `nCode`, giving ratios of 1, 2, 4 and 8.
- R10: While `rstN` is 0, `mActive` and `nCode` are 0 and the selector is 00. Within three cycles after release, the active values take the parallel pins.
- R11: The bit in the null slot has no effect on any active value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rstN | input | 1 | Asynchronous active-low reset |
| pLoadN | input | 1 | Parallel load strobe, active low |
| mPar | input | 9 | Parallel feedback divide value |
| nPar | input | 2 | Parallel output divide code |
| sClk | input | 1 | Serial shift clock |
| sData | input | 1 | Serial data line |
| sLoad | input | 1 | Serial load strobe |
| mDivClk | input | 1 | Feedback-divider output clock, for the test pin |
| outClk | input | 1 | Output clock, for the test pin |
| mActive | output | 9 | Active feedback divide value |
| nCode | output | 2 | Active output divide code |
| divRatio | output | 4 | Decoded output divide ratio, one-hot |
| testOut | output | 1 | Test pin |
| mOutOfRange | output | 1 | Active feedback value lies outside 10..28 |

## Verification
The bench builds the block with its defaults: a 9-bit feedback value, a 2-bit output code and a lock range of 10 to 28. With these values the full 14-bit serial frame can be driven bit by bit. All four divide ratios and all four selector codes can be reached. The range flag can be checked on both sides of each limit (9, 10, 28, 29).

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  // Strobes passed from the control unit to the datapath.
  typedef struct packed {
    logic parLoad;  // take the parallel pins into the active register
    logic shiftEn;  // shift one serial bit in
    logic xferEn;   // copy the shift register into the transfer stage
    logic applyEn;  // copy the transfer stage into the active register
  } ldStrobe_t;

  typedef enum logic [1:0] {
    TSEL_LOW  = 2'b00,
    TSEL_DATA = 2'b01,
    TSEL_MDIV = 2'b10,
    TSEL_OUT  = 2'b11
  } testSel_t;

endpackage

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pLoadN,
  input  logic      sClk,
  input  logic      sLoad,
  output ldStrobe_t strb
);

  logic sClkQ;
  logic sLoadQ;
  logic pLoadNQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sClkQ   <= 1'b0;
      sLoadQ  <= 1'b0;
      pLoadNQ <= 1'b0;   // a high pLoadN right after reset counts as a capture edge
    end else begin
      sClkQ   <= sClk;
      sLoadQ  <= sLoad;
      pLoadNQ <= pLoadN;
    end
  end

  always_comb begin
    strb         = '0;
    strb.parLoad = !pLoadN || !pLoadNQ;        // transparent low, or the rising edge
    strb.shiftEn = pLoadN && sClk && !sClkQ;
    strb.xferEn  = pLoadN && sLoad;             // transfer stage tracks while load is high
    strb.applyEn = pLoadN && sLoad && sLoadQ;   // active follows one cycle behind
  end

endmodule

// File: rtl/cfgld_dp.sv
module cfgld_dp
  import cfgld_pkg::*;
#(
  parameter int M_WIDTH = 9,
  parameter int N_WIDTH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ldStrobe_t          strb,
  input  logic [M_WIDTH-1:0] mPar,
  input  logic [N_WIDTH-1:0] nPar,
  input  logic               sData,
  output logic [M_WIDTH-1:0] mAct,
  output logic [N_WIDTH-1:0] nAct,
  output testSel_t           tSel
);

  localparam int T_WIDTH = 2;
  localparam int FRAME_W = T_WIDTH + 1 + N_WIDTH + M_WIDTH;
  localparam int XFER_W  = FRAME_W - 1;      // null slot dropped
  localparam int N_LSB   = M_WIDTH;
  localparam int T_LSB   = M_WIDTH + N_WIDTH + 1;

  logic [FRAME_W-1:0] shiftQ;
  logic [XFER_W-1:0]  xferQ;
  logic [M_WIDTH-1:0] mQ;
  logic [N_WIDTH-1:0] nQ;
  testSel_t           tQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (strb.shiftEn) begin
      shiftQ <= {shiftQ[FRAME_W-2:0], sData};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferQ <= '0;
    end else if (strb.xferEn) begin
      xferQ <= {shiftQ[FRAME_W-1:T_LSB],
                shiftQ[N_LSB+N_WIDTH-1:N_LSB],
                shiftQ[M_WIDTH-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mQ <= '0;
      nQ <= '0;
      tQ <= TSEL_LOW;
    end else if (strb.parLoad) begin
      mQ <= mPar;
      nQ <= nPar;
    end else if (strb.applyEn) begin
      mQ <= xferQ[M_WIDTH-1:0];
      nQ <= xferQ[M_WIDTH+N_WIDTH-1:M_WIDTH];
      tQ <= testSel_t'(xferQ[XFER_W-1:XFER_W-T_WIDTH]);
    end
  end

  assign mAct = mQ;
  assign nAct = nQ;
  assign tSel = tQ;

endmodule

// File: rtl/cfgld_out.sv
module cfgld_out
  import cfgld_pkg::*;
#(
  parameter int M_WIDTH = 9,
  parameter int N_WIDTH = 2,
  parameter int M_MIN   = 10,
  parameter int M_MAX   = 28
) (
  input  logic                    parMode,
  input  testSel_t                tSel,
  input  logic                    sData,
  input  logic                    mDivClk,
  input  logic                    outClk,
  input  logic [M_WIDTH-1:0]      mAct,
  input  logic [N_WIDTH-1:0]      nAct,
  output logic                    testOut,
  output logic [(1<<N_WIDTH)-1:0] divRatio,
  output logic                    mOutOfRange
);

  localparam int RATIO_W = 1 << N_WIDTH;

  always_comb begin
    if (parMode) begin
      testOut = 1'b0;
    end else begin
      unique case (tSel)
        TSEL_LOW:  testOut = 1'b0;
        TSEL_DATA: testOut = sData;
        TSEL_MDIV: testOut = mDivClk;
        TSEL_OUT:  testOut = outClk;
        default:   testOut = 1'b0;
      endcase
    end
  end

  for (genvar i = 0; i < RATIO_W; i++) begin : g_ratio
    assign divRatio[i] = (nAct == N_WIDTH'(i));
  end

  assign mOutOfRange = (mAct < M_WIDTH'(M_MIN)) || (mAct > M_WIDTH'(M_MAX));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfgld_pkg::*;
#(
  parameter int M_WIDTH = 9,
  parameter int N_WIDTH = 2,
  parameter int M_MIN   = 10,
  parameter int M_MAX   = 28
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pLoadN,
  input  logic [M_WIDTH-1:0]      mPar,
  input  logic [N_WIDTH-1:0]      nPar,
  input  logic                    sClk,
  input  logic                    sData,
  input  logic                    sLoad,
  input  logic                    mDivClk,
  input  logic                    outClk,
  output logic [M_WIDTH-1:0]      mActive,
  output logic [N_WIDTH-1:0]      nCode,
  output logic [(1<<N_WIDTH)-1:0] divRatio,
  output logic                    testOut,
  output logic                    mOutOfRange
);

  ldStrobe_t strb;
  testSel_t  tSel;

  cfgld_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pLoadN (pLoadN),
    .sClk   (sClk),
    .sLoad  (sLoad),
    .strb   (strb)
  );

  cfgld_dp #(.M_WIDTH(M_WIDTH), .N_WIDTH(N_WIDTH)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .mPar  (mPar),
    .nPar  (nPar),
    .sData (sData),
    .mAct  (mActive),
    .nAct  (nCode),
    .tSel  (tSel)
  );

  cfgld_out #(.M_WIDTH(M_WIDTH), .N_WIDTH(N_WIDTH),
              .M_MIN(M_MIN), .M_MAX(M_MAX)) u_out (
    .parMode     (!pLoadN),
    .tSel        (tSel),
    .sData       (sData),
    .mDivClk     (mDivClk),
    .outClk      (outClk),
    .mAct        (mActive),
    .nAct        (nCode),
    .testOut     (testOut),
    .divRatio    (divRatio),
    .mOutOfRange (mOutOfRange)
  );

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
  parameter int M_WIDTH = 9,
  parameter int N_WIDTH = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    pLoadN,
  input logic [M_WIDTH-1:0]      mPar,
  input logic [N_WIDTH-1:0]      nPar,
  input logic                    sLoad,
  input logic [M_WIDTH-1:0]      mActive,
  input logic [N_WIDTH-1:0]      nCode,
  input logic [(1<<N_WIDTH)-1:0] divRatio,
  input logic                    testOut
);

  a_r1_par_follow: assert property (@(posedge clk) disable iff (!rstN)
    !pLoadN |=> (mActive == $past(mPar)) && (nCode == $past(nPar)));

  a_r7_par_test_low: assert property (@(posedge clk) disable iff (!rstN)
    !pLoadN |-> (testOut == 1'b0));

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (pLoadN && $past(pLoadN) && $past(rstN) && !sLoad) |=> ($stable(mActive) && $stable(nCode)));

  a_r9_ratio_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(divRatio) == 1);

endmodule

bind cfg_loader cfgld_checker #(.M_WIDTH(M_WIDTH), .N_WIDTH(N_WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pLoadN   (pLoadN),
  .mPar     (mPar),
  .nPar     (nPar),
  .sLoad    (sLoad),
  .mActive  (mActive),
  .nCode    (nCode),
  .divRatio (divRatio),
  .testOut  (testOut)
);

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rstN, pLoadN, sClk, sData, sLoad, mDivClk, outClk;
  logic [8:0] mPar;
  logic [1:0] nPar;
  logic [8:0] mActive;
  logic [1:0] nCode;
  logic [3:0] divRatio;
  logic       testOut, mOutOfRange;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_loader u_dut (
    .clk(clk), .rstN(rstN), .pLoadN(pLoadN), .mPar(mPar), .nPar(nPar),
    .sClk(sClk), .sData(sData), .sLoad(sLoad), .mDivClk(mDivClk), .outClk(outClk),
    .mActive(mActive), .nCode(nCode), .divRatio(divRatio),
    .testOut(testOut), .mOutOfRange(mOutOfRange)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sData = b;
    waitCyc(1);
    sClk = 1'b1;
    waitCyc(2);
    sClk = 1'b0;
    waitCyc(1);
  endtask

  task automatic sendFrame(input logic [1:0] t, input logic nb, input logic [1:0] n, input logic [8:0] m);
    logic [13:0] f;
    f = {t, nb, n, m};
    for (int i = 13; i >= 0; i--) sendBit(f[i]);
  endtask

  task automatic pulseLoad();
    sLoad = 1'b1;
    waitCyc(4);
    sLoad = 1'b0;
    waitCyc(2);
  endtask

  task automatic serialLoad(input logic [1:0] t, input logic nb, input logic [1:0] n, input logic [8:0] m);
    sendFrame(t, nb, n, m);
    pulseLoad();
  endtask

  task automatic testReset();
    rstN = 1'b0; pLoadN = 1'b1; mPar = 9'd20; nPar = 2'd1;
    sClk = 0; sData = 0; sLoad = 0; mDivClk = 0; outClk = 0;
    waitCyc(3);
    chk("R10", "mActive in reset", mActive, 0);
    chk("R10", "nCode in reset", nCode, 0);
    chk("R10", "divRatio in reset", divRatio, 1);
    chk("R10", "testOut in reset", testOut, 0);
    rstN = 1'b1;
    waitCyc(3);
    chk("R10", "mActive from pins", mActive, 20);
    chk("R10", "nCode from pins", nCode, 1);
    // serial mode with the selector still 00 after reset: test pin low
    sData = 1'b1; mDivClk = 1'b1; outClk = 1'b1;
    waitCyc(1);
    chk("R10", "testOut selector 00", testOut, 0);
    sData = 0; mDivClk = 0; outClk = 0;
  endtask

  task automatic testParallel();
    pLoadN = 1'b0; mPar = 9'd15; nPar = 2'd2;
    waitCyc(2);
    chk("R1", "mActive follows", mActive, 15);
    chk("R1", "nCode follows", nCode, 2);
    mPar = 9'd12; nPar = 2'd3;
    waitCyc(2);
    chk("R1", "mActive follows change", mActive, 12);
    pLoadN = 1'b1;
    waitCyc(1);
    mPar = 9'd25; nPar = 2'd0;
    waitCyc(3);
    chk("R2", "mActive held", mActive, 12);
    chk("R2", "nCode held", nCode, 3);
  endtask

  task automatic testRange();
    int vals[4] = '{9, 10, 28, 29};
    int exps[4] = '{1, 0, 0, 1};
    pLoadN = 1'b0;
    for (int i = 0; i < 4; i++) begin
      mPar = 9'(vals[i]);
      waitCyc(2);
      chk("R8", $sformatf("flag for M=%0d", vals[i]), mOutOfRange, exps[i]);
    end
    mPar = 9'd511;
    waitCyc(2);
    chk("R8", "flag for M=511", mOutOfRange, 1);
  endtask

  task automatic testRatio();
    pLoadN = 1'b0;
    for (int n = 0; n < 4; n++) begin
      nPar = 2'(n);
      waitCyc(2);
      chk("R9", $sformatf("divRatio for code %0d", n), divRatio, 1 << n);
    end
    pLoadN = 1'b1;
    waitCyc(2);
  endtask

  task automatic testSerial();
    pLoadN = 1'b0; mPar = 9'd11; nPar = 2'd0;
    waitCyc(2);
    pLoadN = 1'b1;
    waitCyc(2);
    sendFrame(2'b00, 1'b1, 2'd3, 9'd17);
    chk("R3", "mActive before sLoad", mActive, 11);
    pulseLoad();
    chk("R3", "mActive serial", mActive, 17);
    chk("R11", "nCode with null=1", nCode, 3);
    serialLoad(2'b00, 1'b0, 2'd1, 9'h155);
    chk("R3", "mActive pattern 0x155", mActive, 'h155);
    chk("R11", "nCode with null=0", nCode, 1);
    serialLoad(2'b00, 1'b1, 2'd0, 9'd0);
    chk("R11", "mActive zero frame null=1", mActive, 0);
    chk("R11", "nCode zero frame null=1", nCode, 0);
  endtask

  task automatic testSelect();
    serialLoad(2'b01, 1'b0, 2'd0, 9'd20);
    sData = 1'b1; waitCyc(1);
    chk("R6", "sel 01 sData=1", testOut, 1);
    sData = 1'b0; waitCyc(1);
    chk("R6", "sel 01 sData=0", testOut, 0);
    serialLoad(2'b10, 1'b0, 2'd0, 9'd20);
    mDivClk = 1'b1; waitCyc(1);
    chk("R6", "sel 10 mDivClk=1", testOut, 1);
    mDivClk = 1'b0; waitCyc(1);
    chk("R6", "sel 10 mDivClk=0", testOut, 0);
    serialLoad(2'b11, 1'b0, 2'd0, 9'd20);
    outClk = 1'b1; waitCyc(1);
    chk("R6", "sel 11 outClk=1", testOut, 1);
    pLoadN = 1'b0; waitCyc(1);
    chk("R7", "parallel forces low", testOut, 0);
    pLoadN = 1'b1; waitCyc(2);
    chk("R7", "selector back after parallel", testOut, 1);
    outClk = 1'b0; waitCyc(1);
    chk("R6", "sel 11 outClk=0", testOut, 0);
    serialLoad(2'b00, 1'b0, 2'd0, 9'd20);
    sData = 1'b1; mDivClk = 1'b1; outClk = 1'b1; waitCyc(1);
    chk("R6", "sel 00 low", testOut, 0);
    sData = 0; mDivClk = 0; outClk = 0;
  endtask

  task automatic testTransparent();
    sLoad = 1'b1;
    waitCyc(2);
    sendFrame(2'b00, 1'b0, 2'd2, 9'd23);
    waitCyc(3);
    chk("R5", "mActive while sLoad high", mActive, 23);
    chk("R5", "nCode while sLoad high", nCode, 2);
    sLoad = 1'b0;
    waitCyc(2);
    sendFrame(2'b00, 1'b0, 2'd1, 9'd14);
    waitCyc(3);
    chk("R4", "mActive latched after fall", mActive, 23);
    chk("R4", "nCode latched after fall", nCode, 2);
    pulseLoad();
    chk("R3", "mActive next load", mActive, 14);
  endtask

  initial begin
    testReset();
    testParallel();
    testRange();
    testRatio();
    testSerial();
    testSelect();
    testTransparent();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule